// File: doc/BRIEF.md
# Double-Buffered Multi-Mode PWM Generator

This block produces four pulse-width modulated outputs from one shared time base. A single counter runs against a period value, and each channel compares that counter with its own active duty value to decide whether its output is asserted. Software never writes the active duty values directly. Writes go to a per-channel staging register. The staged value is moved into the active register only at points that the counting mode selects, so an output cannot change its pulse shape in the middle of a period.

The time base has four counting modes, selected by `mode_i`. In the two edge-aligned modes the counter ramps up from zero and wraps. In the two center-aligned modes it ramps up and then back down. One of the edge-aligned modes stops after one period. One of the center-aligned modes refreshes duty values twice per period instead of once. A one-cycle strobe, `period_evt_o`, marks every cycle in which the active duty values are refreshed. While the time base is stopped, the outputs are held inactive and the active registers follow the staging registers on every cycle.

The time base is a small state machine with three states. `TB_IDLE` is stopped, with the counter held at zero. `TB_UP` is counting upward. `TB_DOWN` is counting downward, and only the center-aligned modes use it. The transitions are:
- start: `TB_IDLE` to `TB_UP` when a run write of 1 arrives.
- wrap: `TB_UP` to `TB_UP` with the counter reset, at the top in the free-running mode.
- one-shot end: `TB_UP` to `TB_IDLE` at the top in the single-period mode.
- turn-around: `TB_UP` to `TB_DOWN` at the top in the center-aligned modes.
- valley: `TB_DOWN` to `TB_UP` when the count reaches 1.
- stop: any state to `TB_IDLE` on a run write of 0.

Top module: `dbpwm`

## Requirements
- R1: After reset, all four PWM outputs, `period_evt_o` and `running_o` are 0, and every staging and active duty register is 0.
- R2: `mode_i` = 0 selects free-running edge-aligned counting. The counter goes 0,1,…,P and then returns to 0, so one period lasts P+1 cycles (P = `period_i`). A channel output is 1 from count 0 until the count equals its active duty value D, which gives D high cycles per period when 1 ≤ D ≤ P.
- R3: An active duty value of 0 keeps the channel output at 0 for the whole period, in every mode.
- R4: An active duty value greater than P keeps the channel output at 1 for the whole period, in every mode.
- R5: In the edge-aligned modes (`mode_i` 0 or 1), a staged duty value is copied into the active register only on the cycle in which the count equals P. A write made earlier in the same period leaves that period's pulse unchanged.
- R6: While the time base is stopped (`running_o` = 0), the outputs and `period_evt_o` are 0, and each active register takes its staging value on every cycle. A value written while stopped therefore sets the first period after a start.
- R7: `mode_i` = 2 selects up/down counting. The counter goes 0,1,…,P and then back down P−1,…,1, so a period lasts 2P cycles. A channel output is 1 while the count is below D, which gives 2D−1 high cycles per period when 1 ≤ D ≤ P. Duty values are refreshed only on the cycles in `TB_UP` where the count is 0.
- R8: `mode_i` = 3 selects up/down counting with double update. Duty values are refreshed both when the count is 0 in `TB_UP` and when the count equals P in `TB_UP`. A write made in the rising half therefore takes effect in the falling half of the same period.
- R9: `mode_i` = 1 selects single-period mode. The counter runs one edge-aligned period of P+1 cycles and then returns to `TB_IDLE`, so `running_o` drops to 0 without a stop write.
- R10: `period_evt_o` is 1 for exactly one cycle at each refresh point. That gives one strobe per period in modes 0, 1 and 2, and two strobes per period in mode 3, for P ≥ 2.
- R11: A run write (`run_we_i` = 1) with `run_val_i` = 1 starts the time base from count 0. A run write with `run_val_i` = 0 stops it on the next clock edge, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Counting mode: 0 free-running, 1 single-period, 2 up/down, 3 up/down with double update |
| period_i | input | W | Period value P |
| run_we_i | input | 1 | Run-control write strobe |
| run_val_i | input | 1 | Run-control value: 1 starts, 0 stops |
| duty_we_i | input | NCH | Per-channel write strobe for the staging duty registers |
| duty_val_i | input | W | Duty value written to every selected channel |
| pwm_o | output | NCH | PWM outputs, one per channel |
| period_evt_o | output | 1 | One-cycle strobe on each duty refresh |
| running_o | output | 1 | 1 while the time base is counting |

## Verification
A counter that goes wrong inside the time base shows up within one period. Either the number of high cycles per channel per period changes, or the strobe count per window changes. The bench therefore measures high-cycle totals over windows made of whole periods. An active register loaded at the wrong moment shifts the high count of the period in which a write lands. This is why writes are placed at known offsets inside a period, and why both the current period and the following period are checked. A state machine stuck in the wrong state shows at the ports one cycle later, through `running_o` or through outputs that stay inactive.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_SHOT     = 2'd1,
        MODE_UPDN     = 2'd2,
        MODE_UPDN_DBL = 2'd3
    } pwm_mode_e;

    typedef enum logic [1:0] {
        TB_IDLE = 2'd0,
        TB_UP   = 2'd1,
        TB_DOWN = 2'd2
    } tb_state_e;

endpackage

// File: rtl/dbpwm_timebase.sv
module dbpwm_timebase
    import dbpwm_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] period_i,
    input  logic         run_we_i,
    input  logic         run_val_i,
    output logic [W-1:0] cnt_o,
    output logic         run_o,
    output logic         upd_o
);

    localparam logic [W-1:0] ONE = W'(1);

    tb_state_e    state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    pwm_mode_e    mode;
    logic         edge_mode, at_top, at_zero;

    assign mode      = pwm_mode_e'(mode_i);
    assign edge_mode = (mode == MODE_FREE) || (mode == MODE_SHOT);
    assign at_top    = (cnt_q >= period_i);
    assign at_zero   = (cnt_q == '0);

    // next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TB_IDLE: begin
                cnt_d = '0;
                if (run_we_i && run_val_i) state_d = TB_UP;
            end
            TB_UP: begin
                if (at_top) begin
                    if (mode == MODE_SHOT) begin
                        state_d = TB_IDLE;
                        cnt_d   = '0;
                    end else if (edge_mode || (period_i <= ONE)) begin
                        cnt_d = '0;
                    end else begin
                        state_d = TB_DOWN;
                        cnt_d   = cnt_q - ONE;
                    end
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            TB_DOWN: begin
                if (cnt_q <= ONE) begin
                    state_d = TB_UP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            default: begin
                state_d = TB_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (run_we_i && !run_val_i) begin
            state_d = TB_IDLE;
            cnt_d   = '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TB_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        upd_o = 1'b0;
        unique case (state_q)
            TB_IDLE: upd_o = 1'b0;
            TB_UP: begin
                if (edge_mode) upd_o = at_top;
                else           upd_o = at_zero || ((mode == MODE_UPDN_DBL) && at_top);
            end
            TB_DOWN: upd_o = 1'b0;
            default: upd_o = 1'b0;
        endcase
    end

    assign run_o = (state_q != TB_IDLE);
    assign cnt_o = cnt_q;

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TB_IDLE) |-> ((cnt_q == '0) && !upd_o));

    a_r10_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && (period_i >= W'(2))) |=> (!upd_o || (period_i < W'(2))));

    a_r9_shot_end: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == TB_UP) && (mode == MODE_SHOT) && at_top && !run_we_i) |=> !run_o);

    a_r11_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (run_we_i && !run_val_i) |=> !run_o);

endmodule

// File: rtl/dbpwm_channel.sv
module dbpwm_channel #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] period_i,
    input  logic         run_i,
    input  logic         upd_i,
    output logic         pwm_o
);

    logic [W-1:0] stage_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            act_q   <= '0;
        end else begin
            if (we_i)           stage_q <= wdata_i;
            if (!run_i || upd_i) act_q  <= stage_q;
        end
    end

    assign pwm_o = run_i && ((act_q > period_i) || (cnt_i < act_q));

    a_r3_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == '0) |-> !pwm_o);

    a_r4_over_on: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (act_q > period_i)) |-> pwm_o);

    a_r5_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !upd_i) |=> $stable(act_q));

    a_r6_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (act_q == $past(stage_q)));

endmodule

// File: rtl/dbpwm.sv
module dbpwm
    import dbpwm_pkg::*;
#(
    parameter int W   = 12,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     mode_i,
    input  logic [W-1:0]   period_i,
    input  logic           run_we_i,
    input  logic           run_val_i,
    input  logic [NCH-1:0] duty_we_i,
    input  logic [W-1:0]   duty_val_i,
    output logic [NCH-1:0] pwm_o,
    output logic           period_evt_o,
    output logic           running_o
);

    logic [W-1:0] cnt;
    logic         run;
    logic         upd;

    dbpwm_timebase #(.W(W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_i),
        .period_i (period_i),
        .run_we_i (run_we_i),
        .run_val_i(run_val_i),
        .cnt_o    (cnt),
        .run_o    (run),
        .upd_o    (upd)
    );

    for (genvar c = 0; c < NCH; c++) begin : gen_ch
        dbpwm_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (duty_we_i[c]),
            .wdata_i (duty_val_i),
            .cnt_i   (cnt),
            .period_i(period_i),
            .run_i   (run),
            .upd_i   (upd),
            .pwm_o   (pwm_o[c])
        );
    end

    assign period_evt_o = upd;
    assign running_o    = run;

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> ((pwm_o == '0) && !period_evt_o && !running_o));

endmodule

// File: tb/dbpwm_bench.sv
module dbpwm_bench;

    localparam int W   = 12;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     mode_i = 2'd0;
    logic [W-1:0]   period_i = '0;
    logic           run_we_i = 1'b0;
    logic           run_val_i = 1'b0;
    logic [NCH-1:0] duty_we_i = '0;
    logic [W-1:0]   duty_val_i = '0;
    logic [NCH-1:0] pwm_o;
    logic           period_evt_o;
    logic           running_o;

    int checks = 0;
    int errors = 0;
    int hi_cnt [NCH];
    int ev_cnt;

    always #10 clk = ~clk;

    dbpwm #(.W(W), .NCH(NCH)) u_dbpwm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .period_i    (period_i),
        .run_we_i    (run_we_i),
        .run_val_i   (run_val_i),
        .duty_we_i   (duty_we_i),
        .duty_val_i  (duty_val_i),
        .pwm_o       (pwm_o),
        .period_evt_o(period_evt_o),
        .running_o   (running_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic wr_duty(input int ch, input int val);
        @(negedge clk);
        duty_we_i     = '0;
        duty_we_i[ch] = 1'b1;
        duty_val_i    = W'(val);
        @(negedge clk);
        duty_we_i = '0;
    endtask

    task automatic start(input logic [1:0] m, input int per);
        @(negedge clk);
        mode_i    = m;
        period_i  = W'(per);
        run_we_i  = 1'b1;
        run_val_i = 1'b1;
        @(posedge clk);
    endtask

    task automatic stop();
        @(negedge clk);
        run_we_i  = 1'b1;
        run_val_i = 1'b0;
        @(negedge clk);
        run_we_i = 1'b0;
    endtask

    // Sample n cycles at negedges; optionally stage a write after sample wr_at.
    task automatic measure(input int n, input int wr_at, input int wr_ch, input int wr_val);
        for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
        ev_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) if (pwm_o[c]) hi_cnt[c]++;
            if (period_evt_o) ev_cnt++;
            run_we_i  = 1'b0;
            duty_we_i = '0;
            if (i == wr_at) begin
                duty_we_i[wr_ch] = 1'b1;
                duty_val_i       = W'(wr_val);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pwm after reset", int'(pwm_o), 0);
        chk("R1 strobe after reset", int'(period_evt_o), 0);
        chk("R1 running after reset", int'(running_o), 0);
        // staging cleared: start without writes gives all-low outputs
        start(2'd0, 5);
        measure(6, -1, 0, 0);
        chk("R1 cleared duty ch3", hi_cnt[3], 0);
        stop();
    endtask

    task automatic t_edge_free();
        // R6: written while stopped, used by the first period
        wr_duty(0, 0);
        wr_duty(1, 4);
        wr_duty(2, 9);
        wr_duty(3, 4095);
        start(2'd0, 9);
        measure(20, -1, 0, 0);
        chk("R3 duty zero", hi_cnt[0], 0);
        chk("R2 duty 4", hi_cnt[1], 8);
        chk("R2 duty equal to period", hi_cnt[2], 18);
        chk("R4 duty above period", hi_cnt[3], 20);
        chk("R10 edge strobes", ev_cnt, 2);
        chk("R11 running", int'(running_o), 1);
    endtask

    task automatic t_edge_midwrite();
        measure(10, 5, 1, 7);
        chk("R5 mid-period write held", hi_cnt[1], 4);
        measure(10, -1, 0, 0);
        chk("R5 new duty next period", hi_cnt[1], 7);
    endtask

    task automatic t_stop_idle();
        stop();
        chk("R6 pwm low when stopped", int'(pwm_o), 0);
        chk("R11 stop write", int'(running_o), 0);
        measure(5, -1, 0, 0);
        chk("R6 no strobe when stopped", ev_cnt, 0);
        chk("R6 full duty channel low when stopped", hi_cnt[3], 0);
        wr_duty(1, 2);
        start(2'd0, 9);
        measure(10, -1, 0, 0);
        chk("R6 idle write used at start", hi_cnt[1], 2);
        stop();
    endtask

    task automatic t_updown();
        wr_duty(0, 0);
        wr_duty(1, 3);
        wr_duty(2, 8);
        wr_duty(3, 4095);
        start(2'd2, 8);
        measure(16, -1, 0, 0);
        chk("R3 updown duty zero", hi_cnt[0], 0);
        chk("R7 updown duty 3", hi_cnt[1], 5);
        chk("R7 updown duty equal period", hi_cnt[2], 15);
        chk("R4 updown duty above period", hi_cnt[3], 16);
        chk("R10 updown strobes", ev_cnt, 1);
        measure(16, 2, 1, 6);
        chk("R7 write held until zero", hi_cnt[1], 5);
        chk("R7 one strobe per period", ev_cnt, 1);
        measure(16, -1, 0, 0);
        chk("R7 new duty after zero", hi_cnt[1], 11);
        stop();
    endtask

    task automatic t_double();
        wr_duty(1, 3);
        start(2'd3, 8);
        measure(16, 2, 1, 6);
        chk("R8 split period old+new", hi_cnt[1], 8);
        chk("R10 double strobes", ev_cnt, 2);
        measure(16, -1, 0, 0);
        chk("R8 full new period", hi_cnt[1], 11);
        stop();
    endtask

    task automatic t_single();
        wr_duty(1, 2);
        start(2'd1, 5);
        measure(6, -1, 0, 0);
        chk("R9 single period high", hi_cnt[1], 2);
        chk("R9 single strobe", ev_cnt, 1);
        @(negedge clk);
        chk("R9 stopped by itself", int'(running_o), 0);
        measure(6, -1, 0, 0);
        chk("R9 no second period", hi_cnt[3], 0);
        chk("R9 no further strobes", ev_cnt, 0);
    endtask

    initial begin
        t_reset();
        t_edge_free();
        t_edge_midwrite();
        t_stop_idle();
        t_updown();
        t_double();
        t_single();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        summary();
    end

endmodule